// File: doc/BRIEF.md
# Compare-Value Timer with Signed Countdown View

This block is a one-shot style timer driven by a free-running 64-bit system count. Software arms it either by loading an absolute 64-bit deadline or by writing a signed 32-bit interval into a relative window. An interval write sets the deadline to the current count plus the interval. Reading the relative window while the timer is enabled returns how far the deadline still lies ahead of the count, so the value appears to count down toward zero and then go negative. An optional offset input is subtracted from the count, and the result is used in place of the raw count for arming, reading and firing.

A small control register holds an enable bit, an interrupt mask bit and a read-only status bit. The interrupt output is a level. Register accesses from the least-privileged mode are refused when that mode's access permission is off. A refused access has no effect and raises a trap flag that carries class code 0x18.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count is zero. It then rises by exactly one on each clock edge where `tick` is high and holds otherwise. The value is visible on `count` and at register address 3.
- R2: A write to address 2 (the relative view) uses only `reg_wdata[31:0]`, treated as a signed 32-bit value and sign-extended to 64 bits. Bits [63:32] are ignored. The deadline becomes the effective count at that edge plus the extended value.
- R3: The timer condition is true when the enable bit is 1 and (effective count − deadline), taken as a signed 64-bit number, is zero or positive.
- R4: With the enable bit at 0, the condition is false and `irq` is 0. The count keeps running, and a read of the relative view returns zero.
- R5: With the enable bit at 1, a read of address 2 returns deadline − effective count as a 64-bit value.
- R6: The effective count equals count − `offset` when `offset_en` is 1, and equals count otherwise. It is used for arming, reading and firing alike.
- R7: `irq` is high exactly when the enable bit is 1, the condition is true and the mask bit is 0.
- R8: Address 0 is control: bit 0 enable, bit 1 mask, bit 2 a read-only copy of the condition, and all other bits read 0. Address 1 reads and writes the absolute deadline.
- R9: When `priv_user` is 1 and `user_access_en` is 0, a read or write has no effect. In that case read data is 0, `trap` is 1 and `trap_class` is 0x18. In every other case `trap` is 0 and `trap_class` is 0.
- R10: Reset clears the deadline, the enable bit and the mask bit, so `irq` is 0.
- R11: A write takes effect at its clock edge. Status and `irq` reflect the new value in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count increment enable |
| offset_en | input | 1 | Use offset-corrected count |
| offset | input | 64 | Value subtracted from the count |
| priv_user | input | 1 | Access comes from least-privileged mode |
| user_access_en | input | 1 | Permission for least-privileged accesses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 control, 1 deadline, 2 relative view, 3 count |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational |
| trap | output | 1 | Access refused |
| trap_class | output | 6 | Trap class code |
| irq | output | 1 | Level interrupt |
| count | output | 64 | Raw system count |

## Verification
The bench writes negative intervals, which must fire in the very next cycle. A design that compared the two values without sign would leave those deadlines pending for nearly 2^64 cycles. Writes of zero must also fire at once, and they catch a strict greater-than test in place of greater-or-equal. Interval words with random upper halves catch a design that takes 64 bits rather than sign-extending bit 31. Disabling the timer while its condition holds must drop `irq` and zero the view. Large offsets make sure the offset is subtracted in every path: arming, reading and the firing compare. Refused user accesses must leave the control register unchanged, which catches a trap that is flagged but does not actually block the write.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W = 64,
  parameter int VIEW_W = 32,
  parameter logic [5:0] TRAP_CODE = 6'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             offset_en,
  input  logic [CNT_W-1:0] offset,
  input  logic             priv_user,
  input  logic             user_access_en,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             trap,
  output logic [5:0]       trap_class,
  output logic             irq,
  output logic [CNT_W-1:0] count
);
  localparam int EXT_W = CNT_W - VIEW_W;

  logic [CNT_W-1:0] cnt, cmp, eff, diff, interval;
  logic             en, mask, cond, blocked, wr_ok;

  assign blocked  = (reg_wr | reg_rd) & priv_user & ~user_access_en;
  assign wr_ok    = reg_wr & ~blocked;
  assign eff      = offset_en ? cnt - offset : cnt;
  assign diff     = eff - cmp;
  assign cond     = en & ~diff[CNT_W-1];
  assign irq      = cond & ~mask;
  assign interval = {{EXT_W{reg_wdata[VIEW_W-1]}}, reg_wdata[VIEW_W-1:0]};
  assign count    = cnt;
  assign trap       = blocked;
  assign trap_class = blocked ? TRAP_CODE : 6'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      cmp  <= '0;
      en   <= 1'b0;
      mask <= 1'b0;
    end else begin
      cnt <= cnt + {{(CNT_W-1){1'b0}}, tick};
      if (wr_ok) begin
        case (reg_addr)
          2'd0: begin
            en   <= reg_wdata[0];
            mask <= reg_wdata[1];
          end
          2'd1: cmp <= reg_wdata;
          2'd2: cmp <= eff + interval;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && !blocked) begin
      case (reg_addr)
        2'd0: reg_rdata = {{(CNT_W-3){1'b0}}, cond, mask, en};
        2'd1: reg_rdata = cmp;
        2'd2: reg_rdata = en ? cmp - eff : '0;
        default: reg_rdata = cnt;
      endcase
    end
  end
endmodule

module cmp_timer_props #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             en,
  input logic             mask,
  input logic             cond,
  input logic             irq,
  input logic             trap,
  input logic             reg_wr,
  input logic [5:0]       trap_class,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, $past(tick)});
  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !cond && !irq);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en && !mask && cond);
  assert_trap_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> trap_class == 6'h18);
  assert_blocked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && reg_wr) |=> cmp == $past(cmp) && en == $past(en) && mask == $past(mask));
endmodule

bind cmp_timer cmp_timer_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .mask(mask), .cond(cond),
  .irq(irq), .trap(trap), .reg_wr(reg_wr), .trap_class(trap_class),
  .cnt(cnt), .cmp(cmp)
);

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, offset_en = 1'b0;
  logic [63:0] offset = '0, reg_wdata = '0;
  logic        priv_user = 1'b0, user_access_en = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [63:0] reg_rdata, count;
  logic        trap, irq;
  logic [5:0]  trap_class;

  int checks = 0, failures = 0;
  logic [63:0] m_cnt = '0, m_cmp = '0;
  logic        m_en = 1'b0, m_mask = 1'b0;

  always #2 clk = ~clk;

  cmp_timer uut (.*);

  function automatic logic [63:0] m_eff();
    return offset_en ? m_cnt - offset : m_cnt;
  endfunction
  function automatic logic m_cond();
    logic [63:0] d;
    d = m_eff() - m_cmp;
    return m_en && !d[63];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    logic [63:0] n_cnt, n_cmp;
    logic n_en, n_mask, blk;
    n_cnt = m_cnt + {63'd0, tick};
    n_cmp = m_cmp; n_en = m_en; n_mask = m_mask;
    blk = (reg_wr | reg_rd) & priv_user & ~user_access_en;
    if (reg_wr && !blk) begin
      case (reg_addr)
        2'd0: begin n_en = reg_wdata[0]; n_mask = reg_wdata[1]; end
        2'd1: n_cmp = reg_wdata;
        2'd2: n_cmp = m_eff() + {{32{reg_wdata[31]}}, reg_wdata[31:0]};
        default: ;
      endcase
    end
    @(posedge clk);
    m_cnt = n_cnt; m_cmp = n_cmp; m_en = n_en; m_mask = n_mask;
    #0.2;
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc();
  endtask

  task automatic rd_chk(logic [1:0] a, string req, logic [63:0] exp);
    reg_addr = a; reg_rd = 1'b1;
    #0.3;
    chk(req, reg_rdata, exp);
    reg_rd = 1'b0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R7 irq"}, {63'd0, irq}, {63'd0, m_cond() && !m_mask});
    rd_chk(2'd0, {tag, " R8/R3 ctrl"}, {61'd0, m_cond(), m_mask, m_en});
    rd_chk(2'd2, {tag, " R5/R4 view"}, m_en ? m_cmp - m_eff() : 64'd0);
    rd_chk(2'd3, {tag, " R1 count"}, m_cnt);
    rd_chk(2'd1, {tag, " R8 deadline"}, m_cmp);
    chk({tag, " R1 count port"}, count, m_cnt);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    cyc(); cyc();
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 irq", {63'd0, irq}, 64'd0);
    check_all("R10");
    tick = 1'b1;
    repeat (5) cyc();
    check_all("R1 running");
    // R4: view reads zero while disabled
    wr(2'd2, 64'd100);
    check_all("R4 disabled arm");
    // R2/R11: zero interval fires next cycle
    wr(2'd0, 64'h1);
    wr(2'd2, 64'hFFFF_FFFF_0000_0000);
    chk("R11 irq next cycle", {63'd0, irq}, 64'd1);
    check_all("R2 zero");
    // negative interval fires at once
    wr(2'd2, 64'h0000_0000_FFFF_FFF6);
    check_all("R3 negative");
    // positive interval counts down, then fires
    wr(2'd2, 64'hABCD_0000_0000_0004);
    check_all("R5 countdown");
    repeat (3) begin cyc(); check_all("R5 countdown step"); end
    cyc(); check_all("R3 reached");
    // R7: mask hides irq but not status
    wr(2'd0, 64'h3);
    check_all("R7 masked");
    // R4: disable while condition true
    wr(2'd0, 64'h0);
    check_all("R4 disable firing");
    // R8: status bit is read-only
    wr(2'd0, 64'h5);
    check_all("R8 status ro");
    // R6: offset path
    offset_en = 1'b1; offset = 64'h0000_0100_0000_0000;
    wr(2'd1, 64'hFFFF_FF00_0000_0000 + m_cnt + 64'd2);
    check_all("R6 abs offset");
    wr(2'd2, 64'd3);
    check_all("R6 rel offset");
    repeat (3) begin cyc(); check_all("R6 offset step"); end
    offset_en = 1'b0;
    check_all("R6 offset off");
    // R9: refused user access
    priv_user = 1'b1; user_access_en = 1'b0;
    reg_addr = 2'd0; reg_wdata = 64'h0; reg_wr = 1'b1;
    #0.3;
    chk("R9 trap", {63'd0, trap}, 64'd1);
    chk("R9 class", {58'd0, trap_class}, 64'h18);
    cyc();
    reg_addr = 2'd3; reg_rd = 1'b1;
    #0.3;
    chk("R9 blocked read", reg_rdata, 64'd0);
    reg_rd = 1'b0;
    priv_user = 1'b0;
    check_all("R9 after block");
    priv_user = 1'b1; user_access_en = 1'b1;
    reg_addr = 2'd3; reg_rd = 1'b1;
    #0.3;
    chk("R9 permitted trap", {63'd0, trap}, 64'd0);
    chk("R9 permitted class", {58'd0, trap_class}, 64'd0);
    reg_rd = 1'b0;
    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 9);
      tick = $urandom_range(0, 3) != 0;
      priv_user = $urandom_range(0, 3) == 0;
      user_access_en = $urandom_range(0, 1);
      offset_en = $urandom_range(0, 2) == 0;
      offset = {32'd0, $urandom} << $urandom_range(0, 20);
      case (op)
        0: wr(2'd0, {32'd0, $urandom});
        1: wr(2'd1, m_cnt + {{32{1'b0}}, $urandom_range(0, 40)} - 64'd20);
        2, 3: wr(2'd2, {$urandom, 32'd0} | {32'd0, $urandom_range(0, 30)} - 64'd15);
        default: cyc();
      endcase
      priv_user = 1'b0;
      check_all("R3 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule